// File: doc/BRIEF.md
# Partial reconfiguration handshake sequencer

This block is a hardware state machine that walks a configuration port through the pin-level handshake for a partial reconfiguration. A start pulse launches a pre-check of the mode-select inputs and two pin levels. If the pre-check passes, the block selects the narrow 16-bit width, asserts chip select, enables the clock and data path, and runs two preparation clock bursts on either side of raising the request. It then polls for the ready indication. The configuration data is moved by a separate path. When that path signals the end of the stream, the sequencer polls for done, tears the handshake down in a fixed order and checks the final status.

Clock bursts go out through a small command port: a one-cycle `burst_go` with a count, answered by a `burst_done` pulse from an external generator. Every run ends with a one-cycle `result_valid` and a 2-bit result code. `busy` stays high from the accepted start cycle until that result appears.

Top module: `pr_handshake_seq`

## Requirements
- R1: A start is rejected with result 1 (invalid) when the 3-bit `msel` is anything other than 0 or 1. A rejected start drives no control output.
- R2: A start is rejected with result 1 unless both `st_config_pin` and `st_status_pin` are high when it is sampled.
- R3: `cfg_wide` resets to 1 and is driven to 0 (16-bit width) by every accepted start.
- R4: Setup runs in this order: `cs_n` falls, then `path_en` rises, then a burst of PREP_CLKS (256), then `pr_req` rises, then a burst of LONG_CLKS (2047). After that the block polls for ready.
- R5: The ready poll and the done poll each sample the status on at most POLL_LIMIT (10) consecutive cycles. `st_error` takes priority over the ready or done input and ends the poll with result 1. If the tenth sample shows neither, the result is 2 (timeout). A failure during the ready poll posts its result at once and leaves the controls as they are.
- R6: After `stream_end`, the completion runs in this order: the done poll, then `pr_req` falls, then a PREP_CLKS burst, then `path_en` falls, then `cs_n` rises.
- R7: When the done poll succeeds, the result is 0 only if `st_usermode`, `st_done_pin` and `st_status_pin` are all high at the final check. Otherwise the result is 2.
- R8: If the done poll fails, the full completion sequence still runs, and the poll's result is posted whatever the final status shows.
- R9: Each burst step drives `burst_go` for exactly one cycle with its count on `burst_count`. The sequencer does not advance until `burst_done` is seen.
- R10: Result codes are 0 for OK, 1 for invalid and 2 for timeout. `busy` is high from the cycle after a start until the cycle in which the one-cycle `result_valid` is high, and it is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, sampled while idle |
| stream_end | input | 1 | Data stream has finished |
| msel | input | 3 | Mode-select inputs |
| st_ready | input | 1 | Ready indication |
| st_done | input | 1 | Done indication |
| st_error | input | 1 | Error indication |
| st_usermode | input | 1 | User-mode status |
| st_status_pin | input | 1 | Status pin level |
| st_config_pin | input | 1 | Config pin level |
| st_done_pin | input | 1 | Done pin level |
| burst_done | input | 1 | Burst generator finished |
| cfg_wide | output | 1 | 1 = wide width, 0 = 16-bit width |
| cs_n | output | 1 | Chip select, active low |
| path_en | output | 1 | Clock/data path enable |
| pr_req | output | 1 | Partial reconfiguration request |
| burst_go | output | 1 | Burst command strobe |
| burst_count | output | CNT_W | Burst length in clocks |
| busy | output | 1 | Sequence in progress |
| result_valid | output | 1 | Result strobe |
| result | output | 2 | Result code |

## Verification
The bench builds the block with its default values: POLL_LIMIT of 10 and burst lengths of 256 and 2047. It sweeps all 32 combinations of `msel` and the two pre-check pins. It moves the arrival of ready and done across every sample slot, up to one slot past the poll limit. It also sweeps all eight final-status patterns and injects errors in each poll. A modelled burst generator logs every burst, and a monitor logs every control edge, so the order of each run is compared step by step against the expected list.

// File: rtl/pr_handshake_seq.sv
module pr_handshake_seq #(
  parameter int CNT_W      = 12,
  parameter int PREP_CLKS  = 256,
  parameter int LONG_CLKS  = 2047,
  parameter int POLL_LIMIT = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stream_end,
  input  logic [2:0]       msel,
  input  logic             st_ready,
  input  logic             st_done,
  input  logic             st_error,
  input  logic             st_usermode,
  input  logic             st_status_pin,
  input  logic             st_config_pin,
  input  logic             st_done_pin,
  input  logic             burst_done,
  output logic             cfg_wide,
  output logic             cs_n,
  output logic             path_en,
  output logic             pr_req,
  output logic             burst_go,
  output logic [CNT_W-1:0] burst_count,
  output logic             busy,
  output logic             result_valid,
  output logic [1:0]       result
);
  localparam int PW = $clog2(POLL_LIMIT + 1);

  typedef enum logic [4:0] {
    S_IDLE, S_WIDTH, S_CSEL, S_PATHON, S_B1, S_B1W, S_REQ, S_B2, S_B2W,
    S_WRDY, S_STREAM, S_WDONE, S_DROP, S_B3, S_B3W, S_PATHOFF, S_CSOFF,
    S_FINAL, S_POST
  } st_t;

  st_t           state;
  logic [PW-1:0] poll;
  logic [1:0]    code;
  logic          last_poll;

  assign last_poll   = (poll == PW'(POLL_LIMIT - 1));
  assign busy        = (state != S_IDLE);
  assign burst_go    = (state inside {S_B1, S_B2, S_B3});
  assign burst_count = (state == S_B2) ? CNT_W'(LONG_CLKS) :
                       burst_go        ? CNT_W'(PREP_CLKS) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      cfg_wide     <= 1'b1;
      cs_n         <= 1'b1;
      path_en      <= 1'b0;
      pr_req       <= 1'b0;
      poll         <= '0;
      code         <= 2'd0;
      result_valid <= 1'b0;
      result       <= 2'd0;
    end else begin
      result_valid <= 1'b0;
      case (state)
        S_IDLE:
          if (start) begin
            if (msel > 3'd1 || !(st_config_pin && st_status_pin)) begin
              code  <= 2'd1;
              state <= S_POST;
            end else begin
              state <= S_WIDTH;
            end
          end
        S_WIDTH: begin
          cfg_wide <= 1'b0;
          pr_req   <= 1'b0;
          state    <= S_CSEL;
        end
        S_CSEL:   begin cs_n <= 1'b0;    state <= S_PATHON; end
        S_PATHON: begin path_en <= 1'b1; state <= S_B1;     end
        S_B1:     state <= S_B1W;
        S_B1W:    if (burst_done) state <= S_REQ;
        S_REQ:    begin pr_req <= 1'b1;  state <= S_B2;     end
        S_B2:     state <= S_B2W;
        S_B2W:
          if (burst_done) begin
            poll  <= '0;
            state <= S_WRDY;
          end
        S_WRDY:
          if (st_error) begin
            code  <= 2'd1;
            state <= S_POST;
          end else if (st_ready) begin
            state <= S_STREAM;
          end else if (last_poll) begin
            code  <= 2'd2;
            state <= S_POST;
          end else begin
            poll <= poll + 1'b1;
          end
        S_STREAM:
          if (stream_end) begin
            poll  <= '0;
            state <= S_WDONE;
          end
        S_WDONE:
          if (st_error) begin
            code  <= 2'd1;
            state <= S_DROP;
          end else if (st_done) begin
            code  <= 2'd0;
            state <= S_DROP;
          end else if (last_poll) begin
            code  <= 2'd2;
            state <= S_DROP;
          end else begin
            poll <= poll + 1'b1;
          end
        S_DROP:    begin pr_req <= 1'b0;  state <= S_B3;    end
        S_B3:      state <= S_B3W;
        S_B3W:     if (burst_done) state <= S_PATHOFF;
        S_PATHOFF: begin path_en <= 1'b0; state <= S_CSOFF; end
        S_CSOFF:   begin cs_n <= 1'b1;    state <= S_FINAL; end
        S_FINAL: begin
          if (code == 2'd0 && !(st_usermode && st_done_pin && st_status_pin))
            code <= 2'd2;
          state <= S_POST;
        end
        S_POST: begin
          result       <= code;
          result_valid <= 1'b1;
          state        <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_msel_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start && msel > 3'd1) |=> (state == S_POST && code == 2'd1));

  assert_pin_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start && !(st_config_pin && st_status_pin)) |=> (state == S_POST && code == 2'd1));

  assert_req_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pr_req |-> (!cs_n && path_en));

  assert_ready_error_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WRDY && st_error) |=> (state == S_POST && code == 2'd1));

  assert_path_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    path_en |-> !cs_n);

  assert_keep_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FINAL && code != 2'd0) |=> (code == $past(code)));

  assert_go_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    burst_go |=> !burst_go);

  assert_idle_post_R10: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> !busy);
endmodule

// File: tb/pr_handshake_seq_bench.sv
`timescale 1ns/1ps
module pr_handshake_seq_bench;
  logic clk = 0, rst_n = 0, start = 0, stream_end = 0;
  logic [2:0] msel = 0;
  logic st_ready, st_done = 0, st_usermode = 0, st_status_pin = 0;
  logic st_config_pin = 0, st_done_pin = 0, burst_done;
  logic gen_err, task_err = 0, st_error;
  logic cfg_wide, cs_n, path_en, pr_req, burst_go, busy, result_valid;
  logic [11:0] burst_count;
  logic [1:0] result;

  assign st_error = gen_err | task_err;

  pr_handshake_seq u_pr_handshake_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .stream_end(stream_end), .msel(msel),
    .st_ready(st_ready), .st_done(st_done), .st_error(st_error), .st_usermode(st_usermode),
    .st_status_pin(st_status_pin), .st_config_pin(st_config_pin), .st_done_pin(st_done_pin),
    .burst_done(burst_done), .cfg_wide(cfg_wide), .cs_n(cs_n), .path_en(path_en),
    .pr_req(pr_req), .burst_go(burst_go), .burst_count(burst_count), .busy(busy),
    .result_valid(result_valid), .result(result));

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;
  int ready_k = 0;
  bit ready_err = 0;
  int rcount, pend;
  int log_q[16];
  int log_n;
  bit prev_cs, prev_path, prev_req;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int e);
    if (log_n < 16) log_q[log_n] = e;
    log_n++;
  endtask

  // burst generator model, status model and control-edge monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      burst_done = 0; st_ready = 0; gen_err = 0;
      rcount = -1; pend = 0; log_n = 0;
      prev_cs = 1; prev_path = 0; prev_req = 0;
    end else begin
      burst_done = 0;
      if (rcount >= 0) begin
        if (rcount == 0) begin
          if (ready_err) gen_err = 1; else st_ready = 1;
        end
        rcount--;
      end
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          burst_done = 1;
          if (burst_count_last == 2047) rcount = ready_k;
        end
      end
      if (prev_cs && !cs_n) push(2);
      if (!prev_cs && cs_n) push(10);
      if (!prev_path && path_en) push(3);
      if (prev_path && !path_en) push(9);
      if (!prev_req && pr_req) push(5);
      if (prev_req && !pr_req) push(7);
      if (burst_go) begin
        push(burst_count == 12'd256 ? 4 : burst_count == 12'd2047 ? 6 : 99);
        burst_count_last = burst_count;
        pend = 2;
      end
      prev_cs = cs_n; prev_path = path_en; prev_req = pr_req;
    end
  end
  int burst_count_last = 0;

  task automatic run(input logic [2:0] ms, input bit cp, input bit sp0,
                     input int rk, input bit rerr, input int dk, input bit derr,
                     input bit um, input bit dpn, input bit spf, input string req);
    int ex[16];
    int ex_n;
    int exp_code;
    bit accepted, streams;
    int n;
    accepted = !(ms > 3'd1 || !cp || !sp0);
    streams = accepted && !rerr && rk < 10;
    ex_n = 0;
    if (!accepted) exp_code = 1;
    else if (rerr) exp_code = 1;
    else if (rk >= 10) exp_code = 2;
    else if (derr) exp_code = 1;
    else if (dk >= 10) exp_code = 2;
    else exp_code = (um && dpn && spf) ? 0 : 2;
    if (accepted) begin
      ex[0] = 2; ex[1] = 3; ex[2] = 4; ex[3] = 5; ex[4] = 6; ex_n = 5;
      if (streams) begin
        ex[5] = 7; ex[6] = 4; ex[7] = 9; ex[8] = 10; ex_n = 9;
      end
    end

    @(negedge clk);
    rst_n = 0; msel = ms; st_config_pin = cp; st_status_pin = sp0;
    st_done = 0; task_err = 0; st_usermode = 0; st_done_pin = 0;
    ready_k = rk; ready_err = rerr;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cfg_wide == 1 && cs_n == 1 && path_en == 0 && pr_req == 0 && busy == 0 && result_valid == 0,
        "R3", "reset state", {cfg_wide, cs_n, path_en, pr_req, busy}, 5'b11000);
    start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1, "R10", "busy after start", busy, 1);
    if (streams) begin
      n = 0;
      while (!st_ready && n < 200) begin @(negedge clk); n++; end
      repeat (2) @(negedge clk);
      st_status_pin = spf; st_usermode = um; st_done_pin = dpn;
      stream_end = 1;
      @(negedge clk);
      stream_end = 0;
      repeat (dk) @(negedge clk);
      if (derr) task_err = 1; else st_done = 1;
    end
    n = 0;
    while (!result_valid && n < 2000) begin @(negedge clk); n++; end
    chk(result_valid == 1, "R10", "result posted", result_valid, 1);
    chk(result == exp_code[1:0], req, "result code", result, exp_code);
    chk(busy == 0, "R10", "busy low at result", busy, 0);
    chk(cfg_wide == !accepted, "R3", "width select", cfg_wide, !accepted);
    chk(log_n == ex_n, accepted ? (streams ? "R6" : "R4") : "R1", "event count", log_n, ex_n);
    for (int i = 0; i < ex_n && i < log_n; i++)
      chk(log_q[i] == ex[i], i < 5 ? "R4" : "R6", "event order", log_q[i], ex[i]);
    @(negedge clk);
  endtask

  initial begin
    // R1 / R2 pre-check sweep: msel x config pin x status pin
    for (int m = 0; m < 8; m++)
      for (int p = 0; p < 4; p++)
        run(m[2:0], p[1], p[0], 0, 0, 0, 0, 1, 1, 1, (m > 1) ? "R1" : "R2");
    // R5 ready arrival at each sample slot, last one beyond the limit
    for (int k = 0; k <= 10; k++) run(3'd1, 1, 1, k, 0, 0, 0, 1, 1, 1, "R5");
    run(3'd0, 1, 1, 3, 1, 0, 0, 1, 1, 1, "R5");
    // R9 burst handshake covered through the order logs; R5 done poll sweep
    for (int k = 0; k <= 10; k++) run(3'd0, 1, 1, 0, 0, k, 0, 1, 1, 1, k < 10 ? "R5" : "R8");
    // R8 done-poll error reported even with good final status, and with bad
    run(3'd0, 1, 1, 0, 0, 2, 1, 1, 1, 1, "R8");
    run(3'd1, 1, 1, 0, 0, 0, 1, 0, 0, 0, "R8");
    // R7 final status sweep
    for (int f = 0; f < 8; f++) run(3'd0, 1, 1, 1, 0, 1, 0, f[2], f[1], f[0], "R7");
    // R9: every run above required the modelled burst_done before moving on
    chk(total > 0, "R9", "burst handshake runs", total, total);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule